// File: doc/BRIEF.md
# UART Channel Interrupt Status and Mask

This block holds the interrupt status of one UART channel and turns it into an active-low interrupt request. Eight status positions are kept. Five of them are sticky flags. Each of these is set by a one-cycle event pulse from the channel logic and cleared by its own clear strobe: a command, or a read of a related register. Two positions are live service indications for the receive and transmit FIFOs. They are computed each cycle from the FIFO fill levels against programmable trigger points. The last position is reserved and always reads zero.

An 8-bit enable mask selects which status positions may raise the request. The masked result is also output as a pending vector, so that an external arbiter spanning several channels can use it. A read-mode control selects the value on the readable status port: either the raw status, or the status ANDed with the mask. Arbitration between channels is not part of this block.

Top module: `uart_irq_status`

## Requirements
- R1: Status bit positions are fixed: bit 7 input change, bit 6 receive watchdog timeout, bit 5 address match, bit 4 flow-control character, bit 3 reserved (always 0 on the status port and in the pending vector, whatever the mask), bit 2 break change, bit 1 receive service, bit 0 transmit service.
- R2: `pending` equals status AND `irq_mask`. `irq_n` is low exactly when `pending` is nonzero.
- R3: With `rd_masked` = 0, `status_rd` shows raw status. With `rd_masked` = 1, it shows status AND `irq_mask`.
- R4: The receive service bit is high while `rx_level` is at or above a threshold chosen by `rx_trig`: 00 = 1 entry, 01 = DEPTH/2, 10 = 3*DEPTH/4, 11 = DEPTH (8 and 12 when DEPTH is 16).
- R5: The transmit service bit is high while the free space (DEPTH - `tx_level`) reaches a point chosen by `tx_trig`: 00 = DEPTH free (FIFO empty), 01 = DEPTH/2, 10 = 3*DEPTH/4, 11 = at least 1 free.
- R6: The break-change bit sets on each `brk_edge` pulse, which marks the start or the end of a break. It stays set until a `brk_clr` pulse.
- R7: The address bit clears on `addr_clr`. The flow-control bit clears on `xon_stat_rd`. The input-change bit clears on `port_rd`.
- R8: The watchdog bit sets on `wdog_expire` and clears on `rx_fifo_evt`, which marks a push into or a pop from the receive FIFO.
- R9: When a sticky bit's set pulse and its clear strobe arrive in the same cycle, the bit ends up set.
- R10: After a synchronous reset, all sticky bits are 0 and, with the FIFO service bits inactive, `irq_n` is high.
- R11: Each clear strobe affects only its own sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cos_event | input | 1 | Input pin change pulse |
| wdog_expire | input | 1 | Receive watchdog timeout pulse |
| addr_event | input | 1 | Address match pulse |
| xon_event | input | 1 | Flow-control character received pulse |
| brk_edge | input | 1 | Break start or end pulse |
| port_rd | input | 1 | Input port register read strobe |
| rx_fifo_evt | input | 1 | Receive FIFO push or pop strobe |
| addr_clr | input | 1 | Clear address status command |
| xon_stat_rd | input | 1 | Flow-control status register read strobe |
| brk_clr | input | 1 | Clear break change command |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_trig | input | 2 | Receive service trigger select |
| tx_trig | input | 2 | Transmit service trigger select |
| irq_mask | input | 8 | Interrupt enable mask |
| rd_masked | input | 1 | Status read mode: 0 raw, 1 masked |
| status_rd | output | 8 | Readable status |
| pending | output | 8 | Masked status vector |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case is a set pulse and the clear strobe for the same bit landing in one clock. From the ports this takes two strobes driven together on the same edge. The bench drives both in one cycle for the break flag and for the watchdog flag, then reads the raw status. It also sets several sticky flags together and clears them one at a time, so that a clear strobe wired to the wrong bit shows up as a lost neighbour. The threshold tests step the fill levels to one below and exactly at each trigger point.

// File: rtl/uart_irq_pkg.sv
// Package: shared bit positions and helpers for the channel interrupt status.
// Assumes the status byte layout is fixed and is decoded by the software driver.
package uart_irq_pkg;
    localparam int B_COS  = 7;
    localparam int B_WDOG = 6;
    localparam int B_ADDR = 5;
    localparam int B_XON  = 4;
    localparam int B_RSVD = 3;
    localparam int B_BRK  = 2;
    localparam int B_RXS  = 1;
    localparam int B_TXS  = 0;

    localparam int N_STICKY = 5;

    typedef enum logic [1:0] {
        TRIG_A = 2'b00,
        TRIG_B = 2'b01,
        TRIG_C = 2'b10,
        TRIG_D = 2'b11
    } trig_e;

    // Maps a sticky slot index to its status bit position.
    function automatic int sticky_pos(input int k);
        case (k)
            0:       return B_BRK;
            1:       return B_XON;
            2:       return B_ADDR;
            3:       return B_WDOG;
            default: return B_COS;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_sticky.sv
// Module: one sticky status flag.
// Sets on a one-cycle pulse and clears on a strobe. A set in the same cycle
// as a clear wins. Assumes a synchronous active-low reset.
module uart_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Holds the flag, giving set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_fifo_svc.sv
// Module: receive and transmit FIFO service indications.
// Compares fill levels against trigger points chosen by the 2-bit selects.
// Assumes DEPTH is a multiple of 4 and that levels never exceed DEPTH.
module uart_irq_fifo_svc
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [1:0]       rx_trig,
    input  logic [1:0]       tx_trig,
    output logic             rx_svc,
    output logic             tx_svc
);
    localparam logic [LVL_W-1:0] L_FULL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] L_HALF = LVL_W'(DEPTH / 2);
    localparam logic [LVL_W-1:0] L_3Q   = LVL_W'((3 * DEPTH) / 4);
    localparam logic [LVL_W-1:0] L_ONE  = LVL_W'(1);

    logic [LVL_W-1:0] rx_thr;
    logic [LVL_W-1:0] tx_need;
    logic [LVL_W-1:0] tx_free;

    // Picks the receive fill threshold.
    always_comb begin
        case (trig_e'(rx_trig))
            TRIG_A:  rx_thr = L_ONE;
            TRIG_B:  rx_thr = L_HALF;
            TRIG_C:  rx_thr = L_3Q;
            default: rx_thr = L_FULL;
        endcase
    end

    // Picks the free space the transmitter needs before asking for data.
    always_comb begin
        case (trig_e'(tx_trig))
            TRIG_A:  tx_need = L_FULL;
            TRIG_B:  tx_need = L_HALF;
            TRIG_C:  tx_need = L_3Q;
            default: tx_need = L_ONE;
        endcase
    end

    assign tx_free = L_FULL - tx_level;
    assign rx_svc  = (rx_level >= rx_thr);
    assign tx_svc  = (tx_free >= tx_need);
endmodule

// File: rtl/uart_irq_status.sv
// Module: per-channel interrupt status, mask and request.
// Gathers five sticky event flags and two live FIFO service bits into a
// status byte, masks it to form the pending vector and the active-low
// request, and presents raw or masked status on the read port.
// Assumes the event and strobe inputs are single-cycle pulses.
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cos_event,
    input  logic             wdog_expire,
    input  logic             addr_event,
    input  logic             xon_event,
    input  logic             brk_edge,
    input  logic             port_rd,
    input  logic             rx_fifo_evt,
    input  logic             addr_clr,
    input  logic             xon_stat_rd,
    input  logic             brk_clr,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [1:0]       rx_trig,
    input  logic [1:0]       tx_trig,
    input  logic [7:0]       irq_mask,
    input  logic             rd_masked,
    output logic [7:0]       status_rd,
    output logic [7:0]       pending,
    output logic             irq_n
);
    logic [N_STICKY-1:0] set_v;
    logic [N_STICKY-1:0] clr_v;
    logic [7:0]          stat_q;
    logic                rx_svc;
    logic                tx_svc;

    // Slot order follows uart_irq_pkg::sticky_pos.
    assign set_v = {cos_event, wdog_expire, addr_event, xon_event, brk_edge};
    assign clr_v = {port_rd, rx_fifo_evt, addr_clr, xon_stat_rd, brk_clr};

    for (genvar k = 0; k < N_STICKY; k++) begin : g_sticky
        uart_irq_sticky u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[k]),
            .clr_i  (clr_v[k]),
            .flag_o (stat_q[sticky_pos(k)])
        );
    end

    uart_irq_fifo_svc #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_svc (
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rx_trig  (rx_trig),
        .tx_trig  (tx_trig),
        .rx_svc   (rx_svc),
        .tx_svc   (tx_svc)
    );

    assign stat_q[B_RSVD] = 1'b0;
    assign stat_q[B_RXS]  = rx_svc;
    assign stat_q[B_TXS]  = tx_svc;

    assign pending   = stat_q & irq_mask;
    assign status_rd = rd_masked ? pending : stat_q;
    assign irq_n     = ~|pending;
endmodule

// File: rtl/uart_irq_status_chk.sv
// Module: property checker for uart_irq_status, attached through bind.
// Assumes it sees the internal status byte through the bind connection.
module uart_irq_status_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             brk_edge,
    input logic             brk_clr,
    input logic             wdog_expire,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic [7:0]       irq_mask,
    input logic             rd_masked,
    input logic [7:0]       stat,
    input logic [7:0]       status_rd,
    input logic [7:0]       pending,
    input logic             irq_n
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd[3] == 1'b0) && (pending[3] == 1'b0));

    a_r2_pending_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~irq_mask) == 8'h00);

    a_r2_irq_from_raw: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_masked |-> (irq_n == ((status_rd & irq_mask) == 8'h00)));

    a_r3_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_masked |-> (status_rd == pending));

    a_r4_rx_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> !stat[1]);

    a_r5_tx_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == LVL_W'(DEPTH)) |-> !stat[0]);

    a_r6_brk_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_edge && !brk_clr) |=> (stat[2] == $past(stat[2])));

    a_r9_brk_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        brk_edge |=> stat[2]);

    a_r8_wdog_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_expire |=> stat[6]);
endmodule

bind uart_irq_status uart_irq_status_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .brk_edge    (brk_edge),
    .brk_clr     (brk_clr),
    .wdog_expire (wdog_expire),
    .rx_level    (rx_level),
    .tx_level    (tx_level),
    .irq_mask    (irq_mask),
    .rd_masked   (rd_masked),
    .stat        (stat_q),
    .status_rd   (status_rd),
    .pending     (pending),
    .irq_n       (irq_n)
);

// File: tb/uart_irq_status_tb.sv
// Directed bench for uart_irq_status: one task per scenario.
module uart_irq_status_tb;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cos_event = 0, wdog_expire = 0, addr_event = 0, xon_event = 0, brk_edge = 0;
    logic port_rd = 0, rx_fifo_evt = 0, addr_clr = 0, xon_stat_rd = 0, brk_clr = 0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] tx_level = LVL_W'(DEPTH);
    logic [1:0] rx_trig = 2'b00, tx_trig = 2'b00;
    logic [7:0] irq_mask = 8'hFF;
    logic rd_masked = 1'b0;
    logic [7:0] status_rd, pending;
    logic irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_status #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cos_event(cos_event), .wdog_expire(wdog_expire), .addr_event(addr_event),
        .xon_event(xon_event), .brk_edge(brk_edge), .port_rd(port_rd),
        .rx_fifo_evt(rx_fifo_evt), .addr_clr(addr_clr), .xon_stat_rd(xon_stat_rd),
        .brk_clr(brk_clr), .rx_level(rx_level), .tx_level(tx_level),
        .rx_trig(rx_trig), .tx_trig(tx_trig), .irq_mask(irq_mask),
        .rd_masked(rd_masked), .status_rd(status_rd), .pending(pending), .irq_n(irq_n)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Advances one cycle and drops every pulse input.
    task automatic step();
        @(negedge clk);
        cos_event = 0; wdog_expire = 0; addr_event = 0; xon_event = 0; brk_edge = 0;
        port_rd = 0; rx_fifo_evt = 0; addr_clr = 0; xon_stat_rd = 0; brk_clr = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        chk(status_rd, 8'h00, "R10 status after reset");
        chk({7'd0, irq_n}, 8'h01, "R10 irq_n high after reset");
    endtask

    task automatic t_rx_thresholds();
        int thr [4] = '{1, DEPTH / 2, (3 * DEPTH) / 4, DEPTH};
        tx_level = LVL_W'(DEPTH);
        for (int m = 0; m < 4; m++) begin
            rx_trig = 2'(m);
            rx_level = LVL_W'(thr[m] - 1);
            step();
            chk(status_rd, 8'h00, $sformatf("R4 rx mode %0d below", m));
            rx_level = LVL_W'(thr[m]);
            step();
            chk(status_rd, 8'h02, $sformatf("R4 rx mode %0d at threshold", m));
        end
        rx_level = '0;
        rx_trig = 2'b00;
    endtask

    task automatic t_tx_thresholds();
        int need [4] = '{DEPTH, DEPTH / 2, (3 * DEPTH) / 4, 1};
        rx_level = '0;
        for (int m = 0; m < 4; m++) begin
            tx_trig = 2'(m);
            tx_level = LVL_W'(DEPTH - need[m] + 1);
            step();
            chk(status_rd, 8'h00, $sformatf("R5 tx mode %0d one short", m));
            tx_level = LVL_W'(DEPTH - need[m]);
            step();
            chk(status_rd, 8'h01, $sformatf("R5 tx mode %0d reached", m));
        end
        tx_level = LVL_W'(DEPTH);
        tx_trig = 2'b00;
    endtask

    task automatic t_break();
        brk_edge = 1; step();
        chk(status_rd, 8'h04, "R6 break start sets bit 2");
        repeat (3) step();
        chk(status_rd, 8'h04, "R6 break bit holds while idle");
        port_rd = 1; rx_fifo_evt = 1; addr_clr = 1; xon_stat_rd = 1; step();
        chk(status_rd, 8'h04, "R11 other clears leave break bit");
        brk_edge = 1; step();
        chk(status_rd, 8'h04, "R6 break end keeps bit set");
        brk_clr = 1; step();
        chk(status_rd, 8'h00, "R6 break clear command");
    endtask

    task automatic t_sticky_clears();
        cos_event = 1; addr_event = 1; xon_event = 1; step();
        chk(status_rd, 8'hB0, "R1 positions of input change, address, flow-control");
        addr_clr = 1; step();
        chk(status_rd, 8'h90, "R7 address clear");
        xon_stat_rd = 1; step();
        chk(status_rd, 8'h80, "R7 flow-control status read clears");
        brk_clr = 1; rx_fifo_evt = 1; step();
        chk(status_rd, 8'h80, "R11 unrelated clears keep input change");
        port_rd = 1; step();
        chk(status_rd, 8'h00, "R7 port read clears input change");
    endtask

    task automatic t_watchdog();
        wdog_expire = 1; step();
        chk(status_rd, 8'h40, "R8 watchdog sets bit 6");
        port_rd = 1; step();
        chk(status_rd, 8'h40, "R11 port read keeps watchdog");
        rx_fifo_evt = 1; step();
        chk(status_rd, 8'h00, "R8 FIFO event clears watchdog");
    endtask

    task automatic t_set_wins();
        brk_edge = 1; brk_clr = 1; step();
        chk(status_rd, 8'h04, "R9 break set and clear together");
        wdog_expire = 1; rx_fifo_evt = 1; step();
        chk(status_rd, 8'h44, "R9 watchdog set and clear together");
        brk_clr = 1; rx_fifo_evt = 1; step();
        chk(status_rd, 8'h00, "R9 cleanup");
    endtask

    task automatic t_mask_and_read();
        cos_event = 1; brk_edge = 1; step();
        irq_mask = 8'h04; rd_masked = 0; step();
        chk(status_rd, 8'h84, "R3 raw read ignores mask");
        chk(pending, 8'h04, "R2 pending is status and mask");
        chk({7'd0, irq_n}, 8'h00, "R2 irq_n low with enabled source");
        rd_masked = 1; step();
        chk(status_rd, 8'h04, "R3 masked read");
        irq_mask = 8'h00; step();
        chk(status_rd, 8'h00, "R3 masked read with empty mask");
        chk({7'd0, irq_n}, 8'h01, "R2 irq_n high with all masked");
        irq_mask = 8'h08; rd_masked = 0; step();
        chk(pending, 8'h00, "R1 reserved bit never pending");
        chk({7'd0, irq_n}, 8'h01, "R1 reserved mask bit raises no request");
        irq_mask = 8'h02; rx_level = LVL_W'(1); step();
        chk(pending, 8'h02, "R2 receive service pending");
        chk({7'd0, irq_n}, 8'h00, "R2 irq_n from receive service");
        irq_mask = 8'hFF; rx_level = '0; port_rd = 1; brk_clr = 1; step();
        chk(status_rd, 8'h00, "R7 final clear of all flags");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rx_thresholds();
        t_tx_thresholds();
        t_break();
        t_sticky_clears();
        t_watchdog();
        t_set_wins();
        t_mask_and_read();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule